// File: doc/BRIEF.md
# Sparse DFT Bin Energy Extractor

This block turns a window of 128 complex baseband samples into a compact frequency-energy signature. It works out the discrete Fourier transform only at every fourth bin (0, 4, 8 … 124). For each of these 32 bins it reports the squared magnitude, real² + imag², scaled down and clipped to a 16-bit unsigned feature. Phase is discarded. A downstream classifier reads the 32 features as one vector.

Samples enter one at a time over a valid/ready handshake as signed Q1.15 I/Q pairs. The rotation factors are generated inside the block from a 128-entry sine table. The block has only one complex multiplier for accumulation and one squaring pair for the energy step. It therefore spends one cycle per bin for every sample it accepts. When the last sample of a window has been accumulated, it spends one more cycle per bin forming the energies. It then presents the vector until it is accepted. Input is refused from the moment the vector appears until the output handshake completes. A new window starts straight after that.

Top module: `dft_energy_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, in_ready is 1 and out_valid is 0.
- R2: After each accepted sample (in_valid and in_ready high at a clock edge), in_ready stays low for exactly 32 cycles. If that sample was not the 128th of its window, in_ready is then high again.
- R3: The feature for bin k = 4·b sits at out_feat[16·b+15 : 16·b], for b = 0..31. It is derived from X_k = Σ over n = 0..127 of (I[n] + jQ[n])·(C[m] − jS[m]), with m = (k·n) mod 128. So Re = Σ(I·C + Q·S) and Im = Σ(Q·C − I·S).
- R4: S[i] is the sine of 2πi/128 in Q1.15. It is computed as follows. Fold i into a quarter-wave index m over 0..32, mirrored in the second and fourth quarters and negated in the last two. Evaluate a 7-term odd Taylor series in Q30 with x = m·round(π·2³⁰)·2/128. Every product is rescaled by truncating division by 2³⁰. Round to Q15 by adding 2¹⁴ and dividing by 2¹⁵, and clamp to 32767. C[i] = S[(i+32) mod 128].
- R5: Re and Im are each arithmetically shifted right by 16. Their squares are added, and the sum is shifted right by 16 and saturated to 65535.
- R6: out_valid rises 64 cycles after the edge that accepts the 128th sample. It then stays high, with out_feat unchanged, until a clock edge with out_ready high.
- R7: in_ready is never high together with out_valid. in_valid is ignored whenever in_ready is low. in_ready returns in the cycle after the output handshake.
- R8: Each window's features depend only on that window's samples, with nothing carried over from earlier windows.
- R9: A window of 128 samples at the negative full-scale value (−32768 on both I and Q) accumulates without wrapping, so bin 0 reads 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | 16 | In-phase sample, signed Q1.15 |
| in_q | input | 16 | Quadrature sample, signed Q1.15 |
| out_valid | output | 1 | Feature vector available |
| out_ready | input | 1 | Downstream takes the vector |
| out_feat | output | 512 | 32 packed 16-bit bin energies, bin 0 in the low bits |

## Verification
The properties assume that reset is synchronous, active high and held for at least one edge. They also assume that every input changes only away from the rising edge, so that each accepted sample is counted exactly once by the checker's window counter. The bench drives all inputs on the falling edge. It asserts in_valid with junk data while the block is busy or holding a result, to show those offers are refused. It also withholds out_ready for varying numbers of cycles, so the hold-until-accepted property is exercised over several delays.

// File: rtl/dft_energy_pkg.sv
package dft_energy_pkg;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_CALC   = 2'd1,
    ST_ENERGY = 2'd2,
    ST_DONE   = 2'd3
  } eng_state_t;

  localparam int     TW_W         = 16;
  localparam longint PI_Q30       = 64'sd3373259426;
  localparam longint ONE_Q30      = 64'sd1073741824;
  localparam int     TAYLOR_TERMS = 6;

  // Sine of a first-quadrant angle (m / (n_pts/4) of a right angle), Q30.
  function automatic longint quarter_sine_q30(int m, int n_pts);
    longint x, x2, term, sum;
    x    = (longint'(m) * PI_Q30 * 64'sd2) / longint'(n_pts);
    x2   = (x * x) / ONE_Q30;
    term = x;
    sum  = x;
    for (int k = 1; k <= TAYLOR_TERMS; k++) begin
      term = -((term * x2) / ONE_Q30) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // Full-circle sine entry in Q1.15, folded onto the first quadrant.
  function automatic logic signed [TW_W-1:0] sine_q15(int idx, int n_pts);
    int     q, i, quad, m;
    longint r;
    q    = n_pts / 4;
    i    = idx % n_pts;
    quad = i / q;
    m    = i % q;
    if (quad % 2 == 1) m = q - m;
    r = (quarter_sine_q30(m, n_pts) + 64'sd16384) / 64'sd32768;
    if (r > 64'sd32767) r = 64'sd32767;
    if (quad >= 2) r = -r;
    return TW_W'(r);
  endfunction

endpackage

// File: rtl/dft_twiddle_rom.sv
module dft_twiddle_rom #(
  parameter int N_PTS = 128,
  parameter int IDX_W = $clog2(N_PTS)
) (
  input  logic [IDX_W-1:0]                            idx,
  output logic signed [dft_energy_pkg::TW_W-1:0]      cos_o,
  output logic signed [dft_energy_pkg::TW_W-1:0]      sin_o
);
  localparam int TWW = dft_energy_pkg::TW_W;

  logic signed [TWW-1:0] sin_tab [N_PTS];
  logic [IDX_W-1:0]      cos_idx;

  generate
    for (genvar g = 0; g < N_PTS; g++) begin : g_tab
      assign sin_tab[g] = dft_energy_pkg::sine_q15(g, N_PTS);
    end
  endgenerate

  // Cosine is the sine a quarter turn further on.
  assign cos_idx = idx + IDX_W'(N_PTS / 4);
  assign sin_o   = sin_tab[idx];
  assign cos_o   = sin_tab[cos_idx];
endmodule

// File: rtl/dft_cmac.sv
module dft_cmac #(
  parameter int SW    = 16,
  parameter int TWW   = 16,
  parameter int ACC_W = 48
) (
  input  logic signed [SW-1:0]    xi,
  input  logic signed [SW-1:0]    xq,
  input  logic signed [TWW-1:0]   c,
  input  logic signed [TWW-1:0]   s,
  input  logic                    first,
  input  logic signed [ACC_W-1:0] acc_re_i,
  input  logic signed [ACC_W-1:0] acc_im_i,
  output logic signed [ACC_W-1:0] acc_re_o,
  output logic signed [ACC_W-1:0] acc_im_o
);
  localparam int PW = SW + TWW;

  logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [PW:0]   t_re, t_im;
  logic signed [ACC_W-1:0] base_re, base_im;

  // (xi + j xq) * (c - j s): one complex product per cycle.
  always_comb begin
    p_ic = PW'(xi) * PW'(c);
    p_qs = PW'(xq) * PW'(s);
    p_qc = PW'(xq) * PW'(c);
    p_is = PW'(xi) * PW'(s);
    t_re = {p_ic[PW-1], p_ic} + {p_qs[PW-1], p_qs};
    t_im = {p_qc[PW-1], p_qc} - {p_is[PW-1], p_is};
    base_re  = first ? '0 : acc_re_i;
    base_im  = first ? '0 : acc_im_i;
    acc_re_o = base_re + ACC_W'(t_re);
    acc_im_o = base_im + ACC_W'(t_im);
  end
endmodule

// File: rtl/dft_energy.sv
module dft_energy #(
  parameter int ACC_W = 48,
  parameter int PRE   = 16,
  parameter int POST  = 16,
  parameter int FW    = 16
) (
  input  logic signed [ACC_W-1:0] acc_re,
  input  logic signed [ACC_W-1:0] acc_im,
  output logic [FW-1:0]           feat
);
  localparam int TW   = ACC_W - PRE;
  localparam int SQ_W = 2 * TW;

  function automatic logic [FW-1:0] scale_energy(logic signed [ACC_W-1:0] re,
                                                 logic signed [ACC_W-1:0] im);
    logic signed [TW-1:0]   rt, it;
    logic signed [SQ_W-1:0] r2, i2;
    logic [SQ_W:0]          e, sh;
    rt = TW'(re >>> PRE);
    it = TW'(im >>> PRE);
    r2 = SQ_W'(rt) * SQ_W'(rt);
    i2 = SQ_W'(it) * SQ_W'(it);
    e  = {1'b0, r2} + {1'b0, i2};
    sh = e >> POST;
    if (sh > (SQ_W+1)'({FW{1'b1}})) return '1;
    return FW'(sh);
  endfunction

  assign feat = scale_energy(acc_re, acc_im);
endmodule

// File: rtl/dft_energy_engine.sv
module dft_energy_engine
  import dft_energy_pkg::*;
#(
  parameter int N_SAMP     = 128,
  parameter int BIN_STRIDE = 4,
  parameter int SAMP_W     = 16,
  parameter int ACC_W      = 48,
  parameter int PRE_SHIFT  = 16,
  parameter int POST_SHIFT = 16,
  parameter int FEAT_W     = 16,
  parameter int NBINS      = N_SAMP / BIN_STRIDE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [SAMP_W-1:0] in_i,
  input  logic signed [SAMP_W-1:0] in_q,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NBINS*FEAT_W-1:0]  out_feat
);
  localparam int IDX_W = $clog2(N_SAMP);
  localparam int BIN_W = $clog2(NBINS);

  eng_state_t              st_q;
  logic [IDX_W-1:0]        n_q, ph_q, step_q;
  logic [BIN_W-1:0]        bin_q;
  logic signed [SAMP_W-1:0] xi_q, xq_q;
  logic signed [ACC_W-1:0] acc_re_q [NBINS];
  logic signed [ACC_W-1:0] acc_im_q [NBINS];
  logic [FEAT_W-1:0]       feat_q   [NBINS];

  // Named internal events, also watched by the checker.
  logic sample_take, calc_en, energy_wr, bin_last, win_last, out_fire, first_sample;
  assign sample_take  = (st_q == ST_LOAD) && in_valid;
  assign calc_en      = (st_q == ST_CALC);
  assign energy_wr    = (st_q == ST_ENERGY);
  assign out_fire     = (st_q == ST_DONE) && out_ready;
  assign bin_last     = (bin_q == BIN_W'(NBINS - 1));
  assign win_last     = (n_q == IDX_W'(N_SAMP - 1));
  assign first_sample = (n_q == '0);

  assign in_ready  = (st_q == ST_LOAD);
  assign out_valid = (st_q == ST_DONE);

  logic signed [TW_W-1:0]  tw_c, tw_s;
  logic signed [ACC_W-1:0] nxt_re, nxt_im;
  logic [FEAT_W-1:0]       feat_w;

  dft_twiddle_rom #(.N_PTS(N_SAMP), .IDX_W(IDX_W)) u_rom (
    .idx(ph_q), .cos_o(tw_c), .sin_o(tw_s)
  );

  dft_cmac #(.SW(SAMP_W), .TWW(TW_W), .ACC_W(ACC_W)) u_cmac (
    .xi(xi_q), .xq(xq_q), .c(tw_c), .s(tw_s), .first(first_sample),
    .acc_re_i(acc_re_q[bin_q]), .acc_im_i(acc_im_q[bin_q]),
    .acc_re_o(nxt_re), .acc_im_o(nxt_im)
  );

  dft_energy #(.ACC_W(ACC_W), .PRE(PRE_SHIFT), .POST(POST_SHIFT), .FW(FEAT_W)) u_energy (
    .acc_re(acc_re_q[bin_q]), .acc_im(acc_im_q[bin_q]), .feat(feat_w)
  );

  // Sequencer: one bin per cycle while accumulating, then one per cycle for energy.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_LOAD;
      n_q    <= '0;
      bin_q  <= '0;
      ph_q   <= '0;
      step_q <= '0;
      xi_q   <= '0;
      xq_q   <= '0;
    end else begin
      unique case (st_q)
        ST_LOAD: if (sample_take) begin
          xi_q   <= in_i;
          xq_q   <= in_q;
          step_q <= IDX_W'(32'(n_q) * 32'(BIN_STRIDE));
          ph_q   <= '0;
          bin_q  <= '0;
          st_q   <= ST_CALC;
        end
        ST_CALC: begin
          ph_q  <= ph_q + step_q;
          bin_q <= bin_q + BIN_W'(1);
          if (bin_last) begin
            bin_q <= '0;
            if (win_last) st_q <= ST_ENERGY;
            else begin
              n_q  <= n_q + IDX_W'(1);
              st_q <= ST_LOAD;
            end
          end
        end
        ST_ENERGY: begin
          bin_q <= bin_q + BIN_W'(1);
          if (bin_last) begin
            bin_q <= '0;
            n_q   <= '0;
            st_q  <= ST_DONE;
          end
        end
        ST_DONE: if (out_ready) st_q <= ST_LOAD;
        default: st_q <= ST_LOAD;
      endcase
    end
  end

  // Accumulators need no reset: the first sample of a window overwrites them.
  always_ff @(posedge clk) begin
    if (calc_en) begin
      acc_re_q[bin_q] <= nxt_re;
      acc_im_q[bin_q] <= nxt_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBINS; b++) feat_q[b] <= '0;
    end else if (energy_wr) begin
      feat_q[bin_q] <= feat_w;
    end
  end

  generate
    for (genvar g = 0; g < NBINS; g++) begin : g_pack
      assign out_feat[g*FEAT_W +: FEAT_W] = feat_q[g];
    end
  endgenerate
endmodule

// File: rtl/dft_energy_engine_chk.sv
module dft_energy_engine_chk #(
  parameter int N_SAMP = 128,
  parameter int OUT_W  = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_feat,
  input logic             sample_take,
  input logic             out_fire
);
  localparam int CNT_W = $clog2(N_SAMP + 1);

  logic [CNT_W-1:0] win_cnt;
  always_ff @(posedge clk) begin
    if (rst) win_cnt <= '0;
    else if (out_fire) win_cnt <= '0;
    else if (sample_take) win_cnt <= win_cnt + CNT_W'(1);
  end

  // R1: idle on leaving reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid));

  // R2: an accepted sample blocks the next one
  a_r2_take_blocks: assert property (@(posedge clk) disable iff (rst)
    sample_take |=> !in_ready);

  // R2: never more than one window's worth of samples
  a_r2_count_limit: assert property (@(posedge clk) disable iff (rst)
    sample_take |-> (win_cnt < CNT_W'(N_SAMP)));

  // R6: result only after a full window
  a_r6_full_window: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (win_cnt == CNT_W'(N_SAMP)));

  // R6: vector held until accepted
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_feat)));

  // R7: no input while a result waits
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R7: next window opens right after the handshake
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    out_fire |=> (in_ready && !out_valid));
endmodule

bind dft_energy_engine dft_energy_engine_chk #(
  .N_SAMP(N_SAMP),
  .OUT_W (NBINS * FEAT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_feat   (out_feat),
  .sample_take(sample_take),
  .out_fire   (out_fire)
);

// File: tb/tb_dft_energy_engine.sv
module tb_dft_energy_engine;
  localparam int N  = 128;
  localparam int ST = 4;
  localparam int NB = 32;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic in_ready, out_valid;
  logic out_ready = 1'b0;
  logic [NB*FW-1:0] out_feat;

  always #5 clk = ~clk;

  dft_energy_engine dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_feat(out_feat)
  );

  int checks = 0, failures = 0;
  bit started = 0;
  int cycles = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R4 restated: series evaluated term by term from the power list.
  function automatic int ref_sin(int idx);
    int q, i, quad, m, k;
    longint x, xx, t, acc, r;
    q = N / 4; i = idx % N; quad = i / q; m = i % q;
    if (quad == 1 || quad == 3) m = q - m;
    x = (longint'(m) * 64'sd3373259426 * 2) / N;
    xx = (x * x) / 64'sd1073741824;
    t = x; acc = x; k = 1;
    while (k < 7) begin
      t = (t * xx) / 64'sd1073741824;
      t = -t / longint'((2 * k) * (2 * k + 1));
      acc += t; k++;
    end
    r = (acc + 16384) / 32768;
    if (r > 32767) r = 32767;
    return (quad >= 2) ? -int'(r) : int'(r);
  endfunction

  function automatic int ref_cos(int idx);
    return ref_sin((idx + N / 4) % N);
  endfunction

  // Behavioural model
  int mph = 0, mcnt = 0;
  int qi[$], qq[$];
  int exp_feat[NB];

  task automatic model_features();
    for (int b = 0; b < NB; b++) begin
      longint re = 0, im = 0, rt, it, e;
      for (int n = 0; n < N; n++) begin
        int m = (b * ST * n) % N;
        re += longint'(qi[n]) * ref_cos(m) + longint'(qq[n]) * ref_sin(m);
        im += longint'(qq[n]) * ref_cos(m) - longint'(qi[n]) * ref_sin(m);
      end
      rt = re >>> 16; it = im >>> 16;
      e = (rt * rt + it * it) >>> 16;
      exp_feat[b] = (e > 65535) ? 65535 : int'(e);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mph = 0; mcnt = 0; qi.delete(); qq.delete();
    end else begin
      case (mph)
        0: if (in_valid) begin qi.push_back(int'(in_i)); qq.push_back(int'(in_q)); mph = 1; mcnt = 0; end
        1: begin mcnt++; if (mcnt == NB) begin mcnt = 0; mph = (qi.size() == N) ? 2 : 0; end end
        2: begin mcnt++; if (mcnt == NB) begin model_features(); mph = 3; end end
        default: if (out_ready) begin mph = 0; qi.delete(); qq.delete(); end
      endcase
    end
  end

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (started && !rst) begin
      check("R2 in_ready", longint'(in_ready), longint'(mph == 0));
      check("R6/R7 out_valid", longint'(out_valid), longint'(mph == 3));
      if (mph == 3 && out_valid)
        for (int b = 0; b < NB; b++)
          check($sformatf("R3/R5 feature %0d", b), longint'(out_feat[b*FW +: FW]), longint'(exp_feat[b]));
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000) begin
    failures++;
    $display("FAIL R6 watchdog actual=%0d expected<150000", cycles);
    finish_run();
  end

  task automatic send_window(int mode, bit gappy);
    int si[N], sq[N];
    int n;
    for (int k = 0; k < N; k++) begin
      case (mode)
        0: begin si[k] = 64; sq[k] = 0; end
        1: begin si[k] = ref_cos((8 * k) % N) >>> 8; sq[k] = ref_sin((8 * k) % N) >>> 8; end
        2: begin si[k] = -32768; sq[k] = -32768; end
        default: begin si[k] = int'(16'($urandom)) - 32768; sq[k] = int'(16'($urandom)) - 32768; end
      endcase
    end
    n = 0;
    while (n < N) begin
      @(negedge clk);
      if (!in_ready) begin
        in_valid = 1'b1; in_i = 16'sh5a5a; in_q = -16'sh1234;  // R7: offered while busy
      end else if (gappy && ($urandom % 3 == 0)) begin
        in_valid = 1'b0; in_i = 16'sh7abc; in_q = 16'sh7abc;
      end else begin
        in_valid = 1'b1; in_i = 16'(si[n]); in_q = 16'(sq[n]);
      end
      #1;
      if (in_valid && in_ready) n++;
    end
  endtask

  task automatic take_result(int delay, output int f[NB]);
    do begin
      @(negedge clk);
      in_valid = 1'b1; in_i = 16'sh3c3c; in_q = 16'sh0f0f;  // R7: offered while result pending
    end while (!out_valid);
    repeat (delay) @(negedge clk);
    for (int b = 0; b < NB; b++) f[b] = int'(out_feat[b*FW +: FW]);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b0;
    check("R7 ready after handshake", longint'(in_ready), 1);
  endtask

  int f_a[NB], f_b[NB], f_c[NB], f_d[NB], f_e[NB];

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", longint'(in_ready), 1);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    rst = 1'b0;
    started = 1;
    @(negedge clk);
    check("R1 in_ready after reset", longint'(in_ready), 1);

    send_window(0, 0); take_result(3, f_a);
    check("R4 sine table quarter point", ref_sin(32), 32767);

    send_window(1, 1); take_result(0, f_b);
    begin
      bit peak_ok = 1;
      for (int b = 0; b < NB; b++) if (b != 2 && f_b[b] >= f_b[2]) peak_ok = 0;
      check("R4 tone peak at bin 8", longint'(peak_ok), 1);
    end

    send_window(2, 0); take_result(5, f_c);
    check("R9 full-scale bin 0 saturates", f_c[0], 65535);

    send_window(0, 1); take_result(1, f_d);
    for (int b = 0; b < NB; b++) check($sformatf("R8 repeat window bin %0d", b), f_d[b], f_a[b]);

    send_window(3, 1); take_result(2, f_e);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule